// File: doc/BRIEF.md
# Two-Stage Pipelined Unsigned Multiplier

This block multiplies two unsigned operands and returns their full-width unsigned product. The shift-and-add steps of long multiplication are unrolled into a chain of adders, one per partial-product row. A single bank of registers cuts the chain into two stages of similar depth. The first row of the array needs no adder: it is passed straight through as the starting sum. Every row after it is added in by its own adder, so no adder has an input held at zero.

A request is a one-cycle pulse on `startReq` with both operands present in the same cycle. The block accepts a request in every cycle. With `startReq` held high, it starts a multiplication in every cycle and, once both stages are full, delivers one product per cycle. A valid bit moves through the pipeline alongside the data. `accepted` pulses in the cycle after the request, and `done` pulses one cycle after that, together with the product. All outputs come directly from registers, so they change only on a rising clock edge.

Top module: `pipe_mult`

## Requirements
- R1: When `done` is high, `product` equals the unsigned product of the `opX` and `opY` values sampled with the matching `startReq`, for every operand pair, including 0 and the all-ones value.
- R2: `accepted` is high for exactly the one cycle that follows each cycle in which `startReq` was sampled high, and low after any cycle in which `startReq` was low.
- R3: `done` is high in the second cycle after `startReq` was sampled high, which is the cycle immediately after `accepted`, giving a fixed latency of two clock edges.
- R4: With `startReq` high in consecutive cycles, `done` is high in consecutive cycles, and each product belongs to its own request, in request order.
- R5: Driving `rstN` low clears `accepted` and `done` at once, without waiting for a clock edge.
- R6: While `startReq` is low, the values on `opX` and `opY` have no effect: no `accepted` or `done` pulse comes from that cycle.
- R7: A request that is in flight when reset is asserted is discarded. No `done` appears for it after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the rising edge is active |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | One-cycle request to start a multiplication |
| opX | input | OPW | Multiplicand, unsigned, sampled with startReq |
| opY | input | OPW | Multiplier, unsigned, sampled with startReq |
| accepted | output | 1 | Pulses in the cycle after a request is taken |
| done | output | 1 | Pulses when product holds a valid result |
| product | output | 2*OPW | Unsigned product, valid only while done is high |

## Verification
The bench builds the block with its default values: 4-bit operands and two rows summed in the first stage. At this size the operand space has only 256 pairs, so the bench sweeps every pair back to back with the request held high, which tests the full range and the one-result-per-cycle rate together. Seeded random traffic with gaps between requests then checks the pulse timing around idle cycles, where the operand inputs carry junk. Directed sequences assert reset while a request is inside the pipeline.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  // Load enables passed from the control module to the datapath
  typedef struct packed {
    logic s1Load;  // capture stage-one partial sum and leftover operand bits
    logic s2Load;  // capture the final product
  } pmulCtl_t;
endpackage

// File: rtl/pmul_ctrl.sv
module pmul_ctrl
  import pmul_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  output pmulCtl_t ctl,
  output logic     accepted,
  output logic     done
);
  logic v1Q;  // stage-one valid, also the acknowledge pulse
  logic v2Q;  // stage-two valid, also the result-ready pulse

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1Q <= 1'b0;
      v2Q <= 1'b0;
    end else begin
      v1Q <= startReq;
      v2Q <= v1Q;
    end
  end

  always_comb begin
    ctl.s1Load = startReq;
    ctl.s2Load = v1Q;
  end

  assign accepted = v1Q;
  assign done     = v2Q;

  p_ack_after_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> accepted);
  p_no_ack_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !startReq |=> !accepted);
  p_done_after_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> done);
  p_no_spurious_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    !accepted |=> !done);
endmodule

// File: rtl/pmul_datapath.sv
module pmul_datapath
  import pmul_pkg::*;
#(
  parameter int OPW   = 4,
  parameter int SPLIT = 2   // rows summed in stage one, 1..OPW-1
)(
  input  logic              clk,
  input  logic              rstN,
  input  pmulCtl_t          ctl,
  input  logic [OPW-1:0]    opX,
  input  logic [OPW-1:0]    opY,
  output logic [2*OPW-1:0]  product
);
  localparam int PW   = 2 * OPW;
  localparam int REST = OPW - SPLIT;

  function automatic logic [PW-1:0] shiftedRow(input logic [OPW-1:0] x,
                                               input logic yb,
                                               input int sh);
    return {{OPW{1'b0}}, x & {OPW{yb}}} << sh;
  endfunction

  // Stage one: row 0 passes through, rows 1..SPLIT-1 each get one adder
  logic [PW-1:0] acc1 [SPLIT];
  assign acc1[0] = {{OPW{1'b0}}, opX & {OPW{opY[0]}}};
  for (genvar i = 1; i < SPLIT; i++) begin : g_stage1
    assign acc1[i] = acc1[i-1] + shiftedRow(opX, opY[i], i);
  end

  logic [PW-1:0]   s1Sum;
  logic [OPW-1:0]  s1X;
  logic [REST-1:0] s1Yhi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Sum <= '0;
      s1X   <= '0;
      s1Yhi <= '0;
    end else if (ctl.s1Load) begin
      s1Sum <= acc1[SPLIT-1];
      s1X   <= opX;
      s1Yhi <= opY[OPW-1:SPLIT];
    end
  end

  // Stage two: remaining rows, each added onto the registered sum
  logic [PW-1:0] acc2 [REST+1];
  assign acc2[0] = s1Sum;
  for (genvar j = 0; j < REST; j++) begin : g_stage2
    assign acc2[j+1] = acc2[j] + shiftedRow(s1X, s1Yhi[j], SPLIT + j);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            product <= '0;
    else if (ctl.s2Load)  product <= acc2[REST];
  end

  p_s1_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.s1Load |=> ($stable(s1X) && $stable(s1Sum)));
endmodule

// File: rtl/pipe_mult.sv
module pipe_mult
  import pmul_pkg::*;
#(
  parameter int OPW   = 4,
  parameter int SPLIT = 2
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [OPW-1:0]   opX,
  input  logic [OPW-1:0]   opY,
  output logic             accepted,
  output logic             done,
  output logic [2*OPW-1:0] product
);
  localparam int PW = 2 * OPW;

  pmulCtl_t ctl;

  pmul_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .ctl      (ctl),
    .accepted (accepted),
    .done     (done)
  );

  pmul_datapath #(.OPW(OPW), .SPLIT(SPLIT)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .opX     (opX),
    .opY     (opY),
    .product (product)
  );

  p_product_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (product == PW'($past(opX, 2)) * PW'($past(opY, 2))));
  p_reset_clears_r5: assert property (@(posedge clk)
    !rstN |-> (!accepted && !done));
endmodule

// File: tb/pipe_mult_tb.sv
module pipe_mult_tb;
  localparam int OPW = 4;
  localparam int PW  = 2 * OPW;
  localparam int MAXV = (1 << OPW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [OPW-1:0] opX = '0, opY = '0;
  logic accepted, done;
  logic [PW-1:0] product;

  int vectors = 0;
  int miscompares = 0;

  // expectation for the request sampled one edge earlier
  logic histS = 1'b0;
  logic [PW-1:0] histP = '0;

  always #2 clk = ~clk;

  pipe_mult #(.OPW(OPW), .SPLIT(2)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opX(opX), .opY(opY),
    .accepted(accepted), .done(done), .product(product)
  );

  function automatic logic [PW-1:0] refMul(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
    logic [PW-1:0] acc = '0;
    for (int k = 0; k < OPW; k++) if (b[k]) acc += PW'(a) << k;
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle, then check just after the edge
  task automatic step(input bit s, input logic [OPW-1:0] x, input logic [OPW-1:0] y,
                      input string tag);
    @(negedge clk);
    startReq = s; opX = x; opY = y;
    @(posedge clk); #1;
    check(accepted == s, {tag, " R2 accepted"}, int'(accepted), int'(s));
    check(done == histS, {tag, " R3 done"}, int'(done), int'(histS));
    if (histS) check(product == histP, {tag, " R1 product"}, int'(product), int'(histP));
    histS = s;
    histP = refMul(x, y);
  endtask

  initial begin
    #(200000 * 4);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    #5;
    check(!accepted && !done, "R5 reset state", int'({accepted, done}), 0);
    @(negedge clk); rstN = 1'b1;

    // exhaustive back-to-back sweep: R1, R4
    for (int a = 0; a <= MAXV; a++)
      for (int b = 0; b <= MAXV; b++)
        step(1'b1, OPW'(a), OPW'(b), "R4 sweep");
    step(1'b0, '0, '0, "R4 drain");
    step(1'b0, '0, '0, "R4 drain");

    // directed corners, isolated
    step(1'b1, OPW'(MAXV), OPW'(MAXV), "R1 max");
    step(1'b0, '0, '0, "R1 gap");
    step(1'b1, '0, OPW'(MAXV), "R1 zero");
    step(1'b0, OPW'(MAXV), OPW'(MAXV), "R6 idle junk");
    step(1'b0, OPW'(5), OPW'(9), "R6 idle junk");

    // random traffic with gaps, junk operands while idle: R2, R3, R6
    for (int n = 0; n < 600; n++)
      step(1'(($urandom % 3) != 0), OPW'($urandom), OPW'($urandom), "R6 random");
    step(1'b0, '0, '0, "R3 drain");
    step(1'b0, '0, '0, "R3 drain");

    // R5/R7: reset while a request is in flight
    @(negedge clk);
    startReq = 1'b1; opX = OPW'(7); opY = OPW'(3);
    @(posedge clk); #1;
    check(accepted == 1'b1, "R2 pre-reset accepted", int'(accepted), 1);
    startReq = 1'b0;
    rstN = 1'b0; #0.5;
    check(!accepted && !done, "R5 async clear", int'({accepted, done}), 0);
    @(negedge clk); rstN = 1'b1;
    histS = 1'b0;
    step(1'b0, '0, '0, "R7 flushed");
    step(1'b0, '0, '0, "R7 flushed");
    step(1'b1, OPW'(11), OPW'(13), "R7 after reset");
    step(1'b0, '0, '0, "R7 after reset");
    step(1'b0, '0, '0, "R7 after reset");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule